// File: doc/BRIEF.md
# Logic Analyzer Command Decoder

This block sits behind a serial receiver that has already turned line traffic into bytes. Each byte arrives as a one-cycle `rx_valid` with `rx_data`. The block splits that stream into commands. A command is either a single opcode byte or an opcode byte followed by a 32-bit argument. From these commands it loads the configuration registers of a logic analyzer core and issues one-cycle control strobes.

Host software normally sends a burst of reset opcodes to bring the decoder into step, then sends the settings, then a run opcode. It can also ask the decoder for a fixed four-byte signature. The decoder returns that signature through a byte output with a ready/valid handshake, which feeds a serial transmitter.

Top module: `la_cmd_decoder`

## Requirements
- R1: After reset, every configuration output reads zero, `grp_en` reads all ones, and `tx_valid`, `reset_pulse` and `run_pulse` are low.
- R2: An opcode with bit 7 set is followed by exactly four argument bytes. An opcode with bit 7 clear is complete in one byte. The byte after a complete command is taken as a new opcode.
- R3: The argument bytes are assembled least significant byte first. Opcode 0x80 loads `clk_div` from argument bytes 0 to 2, and argument byte 3 has no effect.
- R4: Opcode 0x81 loads `read_cnt` from argument bytes 0 and 1, and loads `delay_cnt` from argument bytes 2 and 3.
- R5: Opcode 0x82 loads `flags` from argument bytes 0 and 1. `grp_en[g]` is the inverse of `flags[2+g]`, so a 1 in flag bits 2 to 5 disables that group of 8 channels.
- R6: For stage N below NUM_STAGES, opcodes 0xC0+4N, 0xC1+4N and 0xC2+4N load that stage's trigger mask, trigger value and trigger configuration with the full 32-bit argument. Every other stage keeps its values.
- R7: Opcode 0x00 in opcode position raises `reset_pulse` for exactly one cycle. In the same edge it clears every configuration register to zero and cancels any signature reply in progress.
- R8: Five consecutive 0x00 bytes leave the decoder at a frame boundary, from any position inside a long command. The argument bytes among them complete the interrupted command with zero bytes.
- R9: Opcode 0x01 raises `run_pulse` for exactly one cycle and leaves every configuration register unchanged.
- R10: Opcode 0x02 makes `tx_valid` present the bytes 0x31, 0x53, 0x4C, 0x4F in that order, one byte per accepted handshake. `tx_data` stays stable while `tx_ready` is low. An identify opcode received during a reply is ignored.
- R11: Unknown opcodes change no output. An unknown long opcode still consumes its four argument bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | Downstream accepts the reply byte |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply byte |
| reset_pulse | output | 1 | One-cycle reset/abort strobe |
| run_pulse | output | 1 | One-cycle acquisition start strobe |
| trig_mask | output | NUM_STAGES*32 | Trigger masks, stage N at bits [32N+31:32N] |
| trig_value | output | NUM_STAGES*32 | Trigger values, same packing |
| trig_cfg | output | NUM_STAGES*32 | Trigger configurations, same packing |
| clk_div | output | DIV_W | Sample clock divider |
| read_cnt | output | CNT_W | Read count minus one |
| delay_cnt | output | CNT_W | Delay count minus one |
| flags | output | FLAG_W | Flag register |
| grp_en | output | 4 | Channel group enables derived from flags |

## Verification
Each long command is driven with argument bytes that are all distinct. A swap of byte order or a shifted field therefore shows up as a wrong value rather than passing unnoticed. The trigger opcodes are swept over every stage, each stage with different data, to show that the stage offset picks the right stage.

Resynchronisation is tried by breaking off a trigger-mask frame after two argument bytes and then sending five zeros. This separates correct frame counting from a decoder that treats every zero as a reset. Unknown short and long opcodes, each followed by a good command, show that framing survives them. The identify reply is held back by `tx_ready` to show that the first byte stays put before the rest of the signature streams out.

// File: rtl/la_cmd_decoder.sv
module la_cmd_decoder #(
  parameter int NUM_STAGES = 4,
  parameter int DIV_W      = 24,
  parameter int CNT_W      = 16,
  parameter int FLAG_W     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rx_valid,
  input  logic [7:0]               rx_data,
  input  logic                     tx_ready,
  output logic                     tx_valid,
  output logic [7:0]               tx_data,
  output logic                     reset_pulse,
  output logic                     run_pulse,
  output logic [NUM_STAGES*32-1:0] trig_mask,
  output logic [NUM_STAGES*32-1:0] trig_value,
  output logic [NUM_STAGES*32-1:0] trig_cfg,
  output logic [DIV_W-1:0]         clk_div,
  output logic [CNT_W-1:0]         read_cnt,
  output logic [CNT_W-1:0]         delay_cnt,
  output logic [FLAG_W-1:0]        flags,
  output logic [3:0]               grp_en
);

  localparam logic [7:0] OP_RESET = 8'h00;
  localparam logic [7:0] OP_RUN   = 8'h01;
  localparam logic [7:0] OP_IDENT = 8'h02;
  localparam logic [7:0] OP_DIV   = 8'h80;
  localparam logic [7:0] OP_SIZE  = 8'h81;
  localparam logic [7:0] OP_FLAGS = 8'h82;

  logic        in_frame;
  logic [1:0]  arg_cnt;
  logic [7:0]  op_q;
  logic [23:0] arg_q;
  logic [31:0] full_arg;
  logic        tx_busy;
  logic [1:0]  tx_idx;

  logic [31:0] mask_r  [NUM_STAGES];
  logic [31:0] value_r [NUM_STAGES];
  logic [31:0] cfg_r   [NUM_STAGES];

  assign full_arg = {rx_data, arg_q};
  assign tx_valid = tx_busy;
  assign tx_data  = (tx_idx == 2'd0) ? 8'h31 :
                    (tx_idx == 2'd1) ? 8'h53 :
                    (tx_idx == 2'd2) ? 8'h4C : 8'h4F;
  assign grp_en   = ~flags[5:2];

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage_out
    assign trig_mask[s*32 +: 32]  = mask_r[s];
    assign trig_value[s*32 +: 32] = value_r[s];
    assign trig_cfg[s*32 +: 32]   = cfg_r[s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame    <= 1'b0;
      arg_cnt     <= '0;
      op_q        <= '0;
      arg_q       <= '0;
      tx_busy     <= 1'b0;
      tx_idx      <= '0;
      reset_pulse <= 1'b0;
      run_pulse   <= 1'b0;
      clk_div     <= '0;
      read_cnt    <= '0;
      delay_cnt   <= '0;
      flags       <= '0;
      for (int s = 0; s < NUM_STAGES; s++) begin
        mask_r[s]  <= '0;
        value_r[s] <= '0;
        cfg_r[s]   <= '0;
      end
    end else begin
      reset_pulse <= 1'b0;
      run_pulse   <= 1'b0;
      if (tx_busy && tx_ready) begin
        if (tx_idx == 2'd3) tx_busy <= 1'b0;
        tx_idx <= tx_idx + 2'd1;
      end
      if (rx_valid) begin
        if (!in_frame) begin
          if (rx_data[7]) begin
            in_frame <= 1'b1;
            op_q     <= rx_data;
            arg_cnt  <= '0;
          end else begin
            case (rx_data)
              OP_RESET: begin
                reset_pulse <= 1'b1;
                tx_busy     <= 1'b0;
                tx_idx      <= '0;
                clk_div     <= '0;
                read_cnt    <= '0;
                delay_cnt   <= '0;
                flags       <= '0;
                for (int s = 0; s < NUM_STAGES; s++) begin
                  mask_r[s]  <= '0;
                  value_r[s] <= '0;
                  cfg_r[s]   <= '0;
                end
              end
              OP_RUN: run_pulse <= 1'b1;
              OP_IDENT: if (!tx_busy) begin
                tx_busy <= 1'b1;
                tx_idx  <= '0;
              end
              default: ;
            endcase
          end
        end else begin
          arg_cnt <= arg_cnt + 2'd1;
          arg_q   <= {rx_data, arg_q[23:8]};
          if (arg_cnt == 2'd3) begin
            in_frame <= 1'b0;
            case (op_q)
              OP_DIV:   clk_div <= full_arg[DIV_W-1:0];
              OP_SIZE: begin
                read_cnt  <= full_arg[CNT_W-1:0];
                delay_cnt <= full_arg[16 +: CNT_W];
              end
              OP_FLAGS: flags <= full_arg[FLAG_W-1:0];
              default: if (op_q[7:6] == 2'b11) begin
                for (int s = 0; s < NUM_STAGES; s++) begin
                  if (int'(op_q[5:2]) == s) begin
                    case (op_q[1:0])
                      2'd0:    mask_r[s]  <= full_arg;
                      2'd1:    value_r[s] <= full_arg;
                      2'd2:    cfg_r[s]   <= full_arg;
                      default: ;
                    endcase
                  end
                end
              end
            endcase
          end
        end
      end
    end
  end

  // R7
  rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse |-> ($past(rx_valid) && $past(rx_data) == 8'h00));

  // R7
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse |-> (flags == '0 && clk_div == '0 && read_cnt == '0 &&
                     delay_cnt == '0 && trig_mask == '0 && !tx_valid));

  // R9
  run_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_pulse |-> ($past(rx_valid) && $past(rx_data) == 8'h01));

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> ((tx_valid && $stable(tx_data)) || reset_pulse));

  // R10
  tx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> (tx_data == 8'h31));

endmodule

// File: tb/test_la_cmd_decoder.sv
module test_la_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;

  logic clk = 0, rst_n = 0, rx_valid = 0, tx_ready = 0;
  logic [7:0] rx_data = 0;
  logic tx_valid, reset_pulse, run_pulse;
  logic [7:0] tx_data;
  logic [NS*32-1:0] trig_mask, trig_value, trig_cfg;
  logic [23:0] clk_div;
  logic [15:0] read_cnt, delay_cnt, flags;
  logic [3:0] grp_en;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  la_cmd_decoder #(.NUM_STAGES(NS)) i_la_cmd_decoder (
    .clk, .rst_n, .rx_valid, .rx_data, .tx_ready, .tx_valid, .tx_data,
    .reset_pulse, .run_pulse, .trig_mask, .trig_value, .trig_cfg,
    .clk_div, .read_cnt, .delay_cnt, .flags, .grp_en);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic send_long(logic [7:0] op, logic [31:0] arg);
    send(op);
    for (int i = 0; i < 4; i++) send(arg[i*8 +: 8]);
  endtask

  task automatic t_reset_state;
    chk("R1 flags", 32'(flags), 0);
    chk("R1 clk_div", 32'(clk_div), 0);
    chk("R1 counts", {read_cnt, delay_cnt}, 0);
    chk("R1 trig", 32'(|{trig_mask, trig_value, trig_cfg}), 0);
    chk("R1 grp_en", 32'(grp_en), 32'hF);
    chk("R1 strobes", {29'b0, tx_valid, reset_pulse, run_pulse}, 0);
  endtask

  task automatic t_divider;
    send_long(8'h80, 32'h44332211);
    chk("R3 divider lsb-first, byte3 ignored", 32'(clk_div), 32'h332211);
  endtask

  task automatic t_capture_size;
    send_long(8'h81, 32'h56781234);
    chk("R4 read_cnt", 32'(read_cnt), 32'h1234);
    chk("R4 delay_cnt", 32'(delay_cnt), 32'h5678);
  endtask

  task automatic t_flags;
    send_long(8'h82, 32'hFFFF5AA4);
    chk("R5 flags", 32'(flags), 32'h5AA4);
    chk("R5 grp_en", 32'(grp_en), 32'h6);
  endtask

  task automatic t_trigger;
    for (int s = 0; s < NS; s++) begin
      send_long(8'(8'hC0 + 4*s), 32'h1000_0000 + 32'(s) * 32'h0101);
      send_long(8'(8'hC1 + 4*s), 32'h2000_0000 + 32'(s) * 32'h0202);
      send_long(8'(8'hC2 + 4*s), 32'h3000_0000 + 32'(s) * 32'h0303);
    end
    for (int s = 0; s < NS; s++) begin
      chk("R6 mask", trig_mask[s*32 +: 32], 32'h1000_0000 + 32'(s) * 32'h0101);
      chk("R6 value", trig_value[s*32 +: 32], 32'h2000_0000 + 32'(s) * 32'h0202);
      chk("R6 cfg", trig_cfg[s*32 +: 32], 32'h3000_0000 + 32'(s) * 32'h0303);
    end
  endtask

  task automatic t_unknown;
    send_long(8'h83, 32'h01020080);
    send_long(8'hC3, 32'h00000002);
    send(8'h05);
    chk("R11 divider kept", 32'(clk_div), 32'h332211);
    chk("R11 flags kept", 32'(flags), 32'h5AA4);
    chk("R11 mask0 kept", trig_mask[31:0], 32'h1000_0000);
    chk("R11 no strobe", {30'b0, tx_valid, run_pulse}, 0);
    send_long(8'h80, 32'h00ABCDEF);
    chk("R2 framing intact after unknowns", 32'(clk_div), 32'hABCDEF);
  endtask

  task automatic t_run;
    send(8'h01);
    chk("R9 run pulse", 32'(run_pulse), 1);
    chk("R9 config kept", 32'(clk_div), 32'hABCDEF);
    @(negedge clk);
    chk("R9 one cycle", 32'(run_pulse), 0);
  endtask

  task automatic t_identify;
    logic [7:0] sig [4] = '{8'h31, 8'h53, 8'h4C, 8'h4F};
    tx_ready = 0;
    send(8'h02);
    repeat (3) @(negedge clk);
    chk("R10 held valid", 32'(tx_valid), 1);
    chk("R10 held data", 32'(tx_data), 32'h31);
    send(8'h02);
    chk("R10 ignored while busy", 32'(tx_data), 32'h31);
    tx_ready = 1;
    for (int i = 0; i < 4; i++) begin
      chk("R10 sig valid", 32'(tx_valid), 1);
      chk("R10 sig byte", 32'(tx_data), 32'(sig[i]));
      @(negedge clk);
    end
    chk("R10 done", 32'(tx_valid), 0);
    tx_ready = 0;
  endtask

  task automatic t_clear;
    send(8'h00);
    chk("R7 reset pulse", 32'(reset_pulse), 1);
    chk("R7 cleared", {8'(clk_div), flags, 8'(read_cnt)}, 0);
    chk("R7 trig cleared", 32'(|{trig_mask, trig_value, trig_cfg}), 0);
    @(negedge clk);
    chk("R7 one cycle", 32'(reset_pulse), 0);
  endtask

  task automatic t_resync;
    send_long(8'h80, 32'h00112233);
    send(8'hC0); send(8'hAA); send(8'hBB);
    send(8'h00);
    chk("R8 zero as argument no pulse", 32'(reset_pulse), 0);
    send(8'h00);
    chk("R8 frame completed with zeros", trig_mask[31:0], 32'h0000BBAA);
    for (int i = 0; i < 3; i++) send(8'h00);
    chk("R8 reset at boundary", 32'(reset_pulse), 1);
    chk("R8 cleared", trig_mask[31:0], 0);
    send_long(8'h81, 32'h0BAD0CAB);
    chk("R8 aligned after five zeros", {read_cnt, delay_cnt}, 32'h0CAB0BAD);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state;
    t_divider;
    t_capture_size;
    t_flags;
    t_trigger;
    t_unknown;
    t_run;
    t_identify;
    t_clear;
    t_resync;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule